// File: doc/BRIEF.md
# Glitch-Free Five-Source Domain Clock Selector

This block drives one domain clock from any of five free-running input clocks and moves between them without producing short pulses. Software writes a 3-bit source code through a plain write strobe. The block shuts off the old source on that source's own falling edge. It then enables the new source only after the request has passed through a synchronizer clocked by the new source. A read word, valid at all times, returns the requested code and a busy flag. The flag stays high until the register-clock side has seen the handover finish.

The codes run 0 to 4: low-speed oscillator, main oscillator, first PLL, second PLL, third PLL. Codes 5 to 7 are illegal and the block drops them. A second write can arrive while a handover is still in progress. The block keeps the latest legal code and starts a further handover once the current one has finished. A build-time parameter gives a locked variant. That variant always drives source 4, reports code 4, and ignores every write.

Top module: `clksel_top`

## Requirements
- R1: After reset, the read word is 0x1 (code 1, busy clear), and the domain clock follows input clock 1 at once.
- R2: A write whose bits [2:0] hold a legal code (0 to 4) that differs from the requested code makes read bits [2:0] return that code from the next cycle. When busy clears, the domain clock follows the input clock with that index.
- R3: Read bit 3 is the busy flag. It is 1 from the cycle after a write that changes the requested code until the register-clock side has seen the old source gated off and the new one gated on. It is 0 when no handover is outstanding.
- R4: A write whose bits [2:0] hold 5, 6 or 7 leaves the read word and the domain clock unchanged, and busy is not set.
- R5: Write bits above [2:0] have no effect, and read bits above 3 always return 0.
- R6: A legal write that arrives while busy is set replaces the pending code at once (the latest write wins). Busy stays set until the domain clock has moved to that latest code.
- R7: At most one source is gated onto the output at any time. Every high and low phase of the domain clock is at least as long as the shortest half period among the input clocks.
- R8: With the locked parameter set, the read word is always 0x4, every write is ignored, and the domain clock follows input clock 4.
- R9: A write of the code that is already requested starts no handover, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-side clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srcClk | input | 5 | Candidate clocks, index equals select code |
| wrEn | input | 1 | Write strobe, one register-clock cycle |
| wrData | input | CFG_W | Write word, source code in bits [2:0] |
| rdData | output | CFG_W | Read word: code in [2:0], busy in bit 3, zero above |
| domainClk | output | 1 | Selected, glitch-free domain clock |

## Verification
Assertions check on every register-clock cycle that at most one source gate is open, and that the requested code is always legal. They also check that an illegal write leaves the request unchanged, that the active selection holds still during a handover, and that an idle flag means the gates match the requested code. Only the bench scenarios can show that the output really follows the chosen input clock after each handover. The same holds for whether a queued code wins over one overwritten in flight, and for whether any high or low phase of the output is ever shorter than a source half period. The bench measures that last point across all handovers.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
  localparam int SRC_COUNT = 5;
  localparam int SEL_BITS  = 3;

  typedef logic [SRC_COUNT-1:0] srcVec_t;
  typedef logic [SEL_BITS-1:0]  selCode_t;

  // Control to datapath: which gate is wanted and whether a change is in flight.
  typedef struct packed {
    srcVec_t want;
    logic    inFlight;
  } ctlStrobe_t;

  function automatic srcVec_t codeToOh(input selCode_t code);
    srcVec_t vec;
    vec = '0;
    for (int i = 0; i < SRC_COUNT; i++) begin
      if (code == selCode_t'(i)) vec[i] = 1'b1;
    end
    return vec;
  endfunction
endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
module clksel_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int CFG_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LOCKED      = 0,
  parameter int START_CODE  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrData,
  input  srcVec_t          gateOn,
  output ctlStrobe_t       ctl,
  output logic [CFG_W-1:0] rdData
);
  localparam selCode_t START    = selCode_t'(START_CODE);
  localparam selCode_t LAST     = selCode_t'(SRC_COUNT - 1);
  localparam srcVec_t  START_OH = codeToOh(START);
  localparam bit       WRITABLE = (LOCKED == 0);

  selCode_t wrCode;
  logic     unusedHigh;
  logic     legal;
  logic     accept;
  selCode_t reqCode;
  selCode_t selCode;
  logic     switching;
  srcVec_t  gateSeen;
  logic     settled;
  logic     busy;

  assign wrCode     = wrData[SEL_BITS-1:0];
  assign unusedHigh = ^wrData[CFG_W-1:SEL_BITS];
  assign legal      = (wrCode <= LAST);
  assign accept     = WRITABLE && wrEn && legal;

  // Gate status comes from the source domains; resynchronise it here.
  clksel_sync #(
    .WIDTH  (SRC_COUNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(START_OH)
  ) u_gateSync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (gateOn),
    .q    (gateSeen)
  );

  assign settled = (gateSeen == codeToOh(selCode));

  // Latest legal write is kept in reqCode; selCode is the handover in progress.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqCode <= START;
    end else if (accept) begin
      reqCode <= wrCode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selCode   <= START;
      switching <= 1'b0;
    end else if (switching) begin
      if (settled) switching <= 1'b0;
    end else if (selCode != reqCode) begin
      selCode   <= reqCode;
      switching <= 1'b1;
    end
  end

  assign busy         = switching || (selCode != reqCode);
  assign ctl.want     = codeToOh(selCode);
  assign ctl.inFlight = busy;
  assign rdData       = CFG_W'({busy, reqCode});

  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reqCode <= LAST);

  p_idle_gates_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (gateSeen == codeToOh(reqCode)));

  p_illegal_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !legal) |=> $stable(reqCode));

  p_hold_in_flight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (switching && !settled) |=> $stable(selCode));

  p_locked_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (LOCKED != 0) |-> (reqCode == START && !busy));
endmodule

// File: rtl/clksel_datapath.sv
`timescale 1ns/1ps
module clksel_datapath
  import clksel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int START_CODE  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  srcVec_t    srcClk,
  input  ctlStrobe_t ctl,
  output srcVec_t    gateOn,
  output logic       domainClk
);
  for (genvar i = 0; i < SRC_COUNT; i++) begin : g_src
    localparam srcVec_t SELF   = srcVec_t'(1) << i;
    localparam logic    RST_ON = (i == START_CODE);

    logic reqD;
    logic armed;
    logic gateQ;

    // Ask for this gate only when every other gate is already closed.
    assign reqD = ctl.want[i] & ~(|(gateOn & ~SELF));

    clksel_sync #(
      .WIDTH  (1),
      .STAGES (SYNC_STAGES),
      .RST_VAL(RST_ON)
    ) u_reqSync (
      .clk  (srcClk[i]),
      .rst_n(rst_n),
      .d    (reqD),
      .q    (armed)
    );

    // Opening and closing on the falling edge keeps every high phase whole.
    always_ff @(negedge srcClk[i] or negedge rst_n) begin
      if (!rst_n) gateQ <= RST_ON;
      else        gateQ <= armed;
    end

    assign gateOn[i] = gateQ;
  end

  assign domainClk = |(srcClk & gateOn);

  p_single_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gateOn));

  p_idle_gate_is_wanted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.inFlight |-> (gateOn == ctl.want));
endmodule

// File: rtl/clksel_top.sv
`timescale 1ns/1ps
module clksel_top #(
  parameter int CFG_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LOCKED      = 0,
  parameter int LOCK_CODE   = 4,
  parameter int RESET_CODE  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       srcClk,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrData,
  output logic [CFG_W-1:0] rdData,
  output logic             domainClk
);
  localparam int START_CODE = (LOCKED != 0) ? LOCK_CODE : RESET_CODE;

  clksel_pkg::ctlStrobe_t ctl;
  clksel_pkg::srcVec_t    gateOn;

  clksel_ctrl #(
    .CFG_W      (CFG_W),
    .SYNC_STAGES(SYNC_STAGES),
    .LOCKED     (LOCKED),
    .START_CODE (START_CODE)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wrEn  (wrEn),
    .wrData(wrData),
    .gateOn(gateOn),
    .ctl   (ctl),
    .rdData(rdData)
  );

  clksel_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .START_CODE (START_CODE)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .srcClk   (srcClk),
    .ctl      (ctl),
    .gateOn   (gateOn),
    .domainClk(domainClk)
  );
endmodule

// File: tb/clksel_top_tb_top.sv
`timescale 1ns/1ps
module clksel_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [4:0]  srcClk = 5'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic [31:0] rdLock;
  logic        domA;
  logic        domL;

  int nChecks = 0;
  int nFails  = 0;
  logic [2:0] expReq;
  bit   monOn = 1'b0;
  real  tRiseA = -1.0, tFallA = -1.0, minHighA = 1.0e9, minLowA = 1.0e9;

  always #10 clk = ~clk;
  always #30 srcClk[0] = ~srcClk[0];
  always #18 srcClk[1] = ~srcClk[1];
  always #6  srcClk[2] = ~srcClk[2];
  always #8  srcClk[3] = ~srcClk[3];
  always #10 srcClk[4] = ~srcClk[4];

  clksel_top #(.LOCKED(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .srcClk(srcClk), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .domainClk(domA));

  clksel_top #(.LOCKED(1)) dut_locked_i (
    .clk(clk), .rst_n(rst_n), .srcClk(srcClk), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdLock), .domainClk(domL));

  // R7 phase-width monitor on the switching instance
  always @(posedge domA) begin
    if (monOn && tFallA >= 0.0 && ($realtime - tFallA) < minLowA) minLowA = $realtime - tFallA;
    tRiseA = $realtime;
  end
  always @(negedge domA) begin
    if (monOn && tRiseA >= 0.0 && ($realtime - tRiseA) < minHighA) minHighA = $realtime - tRiseA;
    tFallA = $realtime;
  end

  function automatic bit isLegal(input logic [2:0] c);
    return c <= 3'd4;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = $urandom;
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (rdData[3] && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(rdData[3] == 1'b0, req, rdData[3], 0);
  endtask

  // Edges fall on even times; sampling on odd times avoids them.
  task automatic checkFollow(input int k, input bit useLock, input string req);
    int bad = 0;
    @(negedge clk);
    #1;
    for (int s = 0; s < 60; s++) begin
      if ((useLock ? domL : domA) !== srcClk[k]) bad++;
      #2;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic stepWrite(input logic [31:0] data);
    logic [2:0] code = data[2:0];
    bit legal = isLegal(code);
    bit change = legal && (code != expReq);
    doWrite(data);
    if (legal) expReq = code;
    check(rdData[2:0] == expReq, legal ? "R2" : "R4", rdData[2:0], expReq);
    check(rdData[3] == change, change ? "R3" : (legal ? "R9" : "R4"), rdData[3], change);
    check(rdData[31:4] == 28'h0, "R5", rdData[31:4], 0);
    check(rdLock == 32'h4, "R8", rdLock, 32'h4);
    if (change) waitIdle("R3");
    checkFollow(expReq, 1'b0, change ? "R2" : "R4");
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    monOn = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rdData == 32'h1, "R1", rdData, 32'h1);
    checkFollow(1, 1'b0, "R1");
    check(rdLock == 32'h4, "R8", rdLock, 32'h4);
    checkFollow(4, 1'b1, "R8");
    expReq = 3'd1;

    // Directed corners
    stepWrite(32'hFFFF_FFF3);   // R5 upper bits set
    stepWrite(32'h0000_0005);   // R4
    stepWrite(32'h0000_0007);   // R4
    stepWrite(32'h0000_0003);   // R9 same code
    stepWrite(32'h0000_0000);
    stepWrite(32'h0000_0004);
    stepWrite(32'h0000_0001);

    // R6: overwrite while a handover is in flight
    doWrite(32'h3);
    doWrite(32'h0);
    expReq = 3'd0;
    check(rdData == 32'h8, "R6", rdData, 32'h8);
    @(negedge clk);
    check(rdData[3] == 1'b1, "R6", rdData[3], 1);
    waitIdle("R6");
    checkFollow(0, 1'b0, "R6");
    check(rdLock == 32'h4, "R8", rdLock, 32'h4);
    checkFollow(4, 1'b1, "R8");

    // Random mix
    for (int it = 0; it < 30; it++) begin
      stepWrite($urandom);
    end

    check(minHighA >= 6.0, "R7", longint'(minHighA), 6);
    check(minLowA >= 6.0, "R7", longint'(minLowA), 6);
    checkFollow(4, 1'b1, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule